// File: doc/BRIEF.md
# Instruction Prefetch Queue with Deferred Fetch Faults

This block fetches 16-bit instruction words ahead of the decoder. It issues sequential word requests toward a bus controller and holds the returned words in a small ring of slots. Each slot stores the word, the word's address and a one-bit error mark. A bus error on a fetch raises no fault when it happens. The error mark travels with the word and becomes a fault only when the decoder takes that word.

A redirect input covers both branches and context switches. It loads a new fetch address and empties the queue, and any error marks still waiting in the queue vanish without effect. Responses that belong to requests issued before the redirect still return later. The block counts them and discards them. The bus must answer requests in the order it accepted them.

When the decoder takes a marked word, the block raises a one-cycle fault pulse and presents the faulting address. It then delivers nothing more and issues no requests until the next redirect.

Top module: `ifetch_queue`

## Requirements
- R1: After reset the queue is empty (`dec_valid` low), `fetch_fault` is low, and `req_addr` equals the reset address 0x0100.
- R2: Each request accepted (`req_valid` and `req_ready` high) in a cycle without `flush` advances `req_addr` by 2 in the following cycle.
- R3: The number of held words plus the number of live outstanding requests never exceeds the depth of 4. With the decoder idle, exactly 4 requests are accepted after a redirect, and `req_valid` then stays low.
- R4: Words reach the decoder in request order. `dec_addr` starts at the redirect target and rises by 2 per word taken, and `dec_word` is the data the bus returned for that address.
- R5: A response with `rsp_err` high raises no `fetch_fault` while its word sits in the queue or at its head.
- R6: Taking a marked word (`dec_take` with `dec_valid`, no `flush`) makes `fetch_fault` high for exactly the next cycle, with `fault_addr` equal to that word's address.
- R7: After a fault, `dec_valid` and `req_valid` stay low until a `flush`.
- R8: A `flush` empties the queue by the next cycle and drops pending error marks without a fault. It also sets `req_addr` to `flush_addr` with bit 0 cleared.
- R9: Responses to requests accepted before or during a flush cycle never reach the decoder. This includes a response that arrives in the flush cycle itself.
- R10: When `flush` and `dec_take` coincide, the flush wins. The word is not consumed and no fault follows, even for a marked word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Redirect on branch or context switch |
| flush_addr | input | 16 | Redirect target address |
| req_valid | output | 1 | Fetch request offered |
| req_addr | output | 16 | Address of the offered request |
| req_ready | input | 1 | Bus accepts the request this cycle |
| rsp_valid | input | 1 | In-order response present |
| rsp_word | input | 16 | Returned instruction word |
| rsp_err | input | 1 | Response ended in a bus error |
| dec_valid | output | 1 | Head word available to the decoder |
| dec_word | output | 16 | Head word |
| dec_addr | output | 16 | Address of the head word |
| dec_take | input | 1 | Decoder consumes the head word |
| fetch_fault | output | 1 | One-cycle pulse on consuming a marked word |
| fault_addr | output | 16 | Address of the faulting word |

## Verification
The hardest case to reach from the ports is a redirect that lands while old requests are still in flight. A stale response may then arrive in the flush cycle itself, or just after new requests have gone out, and it has to be told apart from the new stream. The random phase creates this case. It answers requests after random delays, flushes now and then, and always flushes after a fault. Every delivered address is checked against the expected stream, so a stale word that slipped through would show up as a wrong address. Directed cases leave a marked word at the head of the queue untouched, then either take it or flush it away in the same cycle as a take.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
    // bytes covered by one instruction word
    localparam int unsigned WORD_BYTES = 2;

    typedef enum logic {
        RUN_ST  = 1'b0,
        HALT_ST = 1'b1
    } run_e;
endpackage

// File: rtl/ifq_store.sv
module ifq_store #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        push,
    input  logic [WORD_W-1:0]           push_word,
    input  logic [ADDR_W-1:0]           push_addr,
    input  logic                        push_err,
    input  logic                        pop,
    output logic [WORD_W-1:0]           head_word,
    output logic [ADDR_W-1:0]           head_addr,
    output logic                        head_err,
    output logic [$clog2(DEPTH+1)-1:0]  held
);
    localparam int unsigned CNTW = $clog2(DEPTH+1);
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] word;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0]             err;
        logic [PW-1:0]                head;
        logic [CNTW-1:0]              count;
    } store_t;

    store_t st_q, st_d;
    int     tail_i;
    int     next_head_i;

    always_comb begin
        st_d        = st_q;
        tail_i      = int'(st_q.head) + int'(st_q.count);
        if (tail_i >= int'(DEPTH)) tail_i = tail_i - int'(DEPTH);
        next_head_i = int'(st_q.head) + 1;
        if (next_head_i >= int'(DEPTH)) next_head_i = 0;

        if (clear) begin
            st_d.head  = '0;
            st_d.count = '0;
        end else begin
            if (push) begin
                st_d.word[tail_i] = push_word;
                st_d.addr[tail_i] = push_addr;
                st_d.err[tail_i]  = push_err;
            end
            if (pop) st_d.head = PW'(next_head_i);
            st_d.count = st_q.count + CNTW'(push) - CNTW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_word = st_q.word[st_q.head];
    assign head_addr = st_q.addr[st_q.head];
    assign head_err  = st_q.err[st_q.head];
    assign held      = st_q.count;

    // R3: a push never lands on a full queue
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear) |-> (st_q.count < CNTW'(DEPTH) || pop));

    // R4: words leave only while something is held
    assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear) |-> (st_q.count != '0));
endmodule

// File: rtl/ifq_fetch_ctl.sv
module ifq_fetch_ctl #(
    parameter int unsigned          DEPTH      = 4,
    parameter int unsigned          ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]    RESET_ADDR = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic [ADDR_W-1:0]           flush_addr,
    input  logic                        halt,
    input  logic [$clog2(DEPTH+1)-1:0]  held,
    input  logic                        req_ready,
    input  logic                        rsp_valid,
    output logic                        req_valid,
    output logic [ADDR_W-1:0]           req_addr,
    output logic                        push,
    output logic [ADDR_W-1:0]           push_addr
);
    localparam int unsigned CNTW = $clog2(DEPTH+1);
    localparam int unsigned TOTW = $clog2(2*DEPTH+1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ifq_pkg::WORD_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] fetch_addr;
        logic [ADDR_W-1:0] rsp_addr;
        logic [TOTW-1:0]   live;
        logic [TOTW-1:0]   stale;
    } ctl_t;

    ctl_t              cq, cd;
    logic              can_issue;
    logic              acc;
    logic              push_c;
    logic [ADDR_W-1:0] target;

    always_comb begin
        cd        = cq;
        push_c    = 1'b0;
        target    = {flush_addr[ADDR_W-1:1], 1'b0};
        can_issue = !halt
                    && ((TOTW'(held) + cq.live) < TOTW'(DEPTH))
                    && ((cq.live + cq.stale) < TOTW'(2*DEPTH));
        acc       = can_issue && req_ready;

        if (flush) begin
            cd.fetch_addr = target;
            cd.rsp_addr   = target;
            cd.live       = '0;
            cd.stale      = cq.stale + cq.live + TOTW'(acc) - TOTW'(rsp_valid);
        end else begin
            if (acc) cd.fetch_addr = cq.fetch_addr + STEP;
            if (rsp_valid) begin
                if (cq.stale != '0) begin
                    cd.stale = cq.stale - 1'b1;
                end else begin
                    push_c      = 1'b1;
                    cd.rsp_addr = cq.rsp_addr + STEP;
                end
            end
            cd.live = cq.live + TOTW'(acc) - TOTW'(push_c);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cq.fetch_addr <= RESET_ADDR;
            cq.rsp_addr   <= RESET_ADDR;
            cq.live       <= '0;
            cq.stale      <= '0;
        end else begin
            cq <= cd;
        end
    end

    assign req_valid = can_issue;
    assign req_addr  = cq.fetch_addr;
    assign push      = push_c;
    assign push_addr = cq.rsp_addr;

    // R2: sequential step of the fetch address
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !flush) |=> (req_addr == $past(req_addr) + STEP));

    // R8: redirect loads the aligned target
    assert_flush_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (req_addr == {$past(flush_addr[ADDR_W-1:1]), 1'b0}));

    // R9: a response only comes back for something in flight
    assert_rsp_expected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((cq.live + cq.stale) != '0));
endmodule

// File: rtl/ifetch_queue.sv
module ifetch_queue #(
    parameter int unsigned          DEPTH      = 4,
    parameter int unsigned          WORD_W     = 16,
    parameter int unsigned          ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]    RESET_ADDR = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_word,
    input  logic              rsp_err,
    output logic              dec_valid,
    output logic [WORD_W-1:0] dec_word,
    output logic [ADDR_W-1:0] dec_addr,
    input  logic              dec_take,
    output logic              fetch_fault,
    output logic [ADDR_W-1:0] fault_addr
);
    import ifq_pkg::*;
    localparam int unsigned CNTW = $clog2(DEPTH+1);

    typedef struct packed {
        run_e              mode;
        logic              fault;
        logic [ADDR_W-1:0] faddr;
    } top_t;

    top_t              tq, td;
    logic [CNTW-1:0]   held;
    logic              push;
    logic [ADDR_W-1:0] push_addr;
    logic              head_err;
    logic              take_ok;

    ifq_fetch_ctl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_ctl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .halt(tq.mode == HALT_ST), .held(held), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .req_valid(req_valid), .req_addr(req_addr),
        .push(push), .push_addr(push_addr)
    );

    ifq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(flush), .push(push),
        .push_word(rsp_word), .push_addr(push_addr), .push_err(rsp_err),
        .pop(take_ok), .head_word(dec_word), .head_addr(dec_addr),
        .head_err(head_err), .held(held)
    );

    assign dec_valid = (held != '0) && (tq.mode == RUN_ST);
    assign take_ok   = dec_take && dec_valid && !flush;

    always_comb begin
        td       = tq;
        td.fault = 1'b0;
        if (flush) begin
            td.mode = RUN_ST;
        end else if (take_ok && head_err) begin
            td.mode  = HALT_ST;
            td.fault = 1'b1;
            td.faddr = dec_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tq.mode  <= RUN_ST;
            tq.fault <= 1'b0;
            tq.faddr <= '0;
        end else begin
            tq <= td;
        end
    end

    assign fetch_fault = tq.fault;
    assign fault_addr  = tq.faddr;

    // R5: a fault follows only the consumption of a marked head word
    assert_fault_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_fault |-> $past(dec_take && dec_valid && head_err && !flush));

    // R6: fault is a single-cycle pulse
    assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_fault |=> !fetch_fault);

    // R7: halted after a fault, nothing delivered or requested
    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_fault |-> (!dec_valid && !req_valid));

    // R8: redirect leaves an empty queue and no fault
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!dec_valid && !fetch_fault));
endmodule

// File: tb/ifetch_queue_test.sv
module ifetch_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [15:0] flush_addr = '0;
    logic        req_valid;
    logic [15:0] req_addr;
    logic        req_ready = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [15:0] rsp_word = '0;
    logic        rsp_err = 1'b0;
    logic        dec_valid;
    logic [15:0] dec_word;
    logic [15:0] dec_addr;
    logic        dec_take = 1'b0;
    logic        fetch_fault;
    logic [15:0] fault_addr;

    always #5 clk = ~clk;

    ifetch_queue uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_err(rsp_err),
        .dec_valid(dec_valid), .dec_word(dec_word), .dec_addr(dec_addr),
        .dec_take(dec_take), .fetch_fault(fetch_fault), .fault_addr(fault_addr)
    );

    int errs = 0;
    int checks = 0;
    bit done = 0;

    // bus model: in-order pending requests
    logic [15:0] pend [0:63];
    int          wr_i = 0, rd_i = 0;

    // knobs
    int          p_ready = 0, p_rsp = 0, p_take = 0, p_flush = 0, p_hflush = 0;
    bit          force_flush = 0, force_take = 0;
    logic [15:0] force_target = '0;

    // reference state
    logic [15:0] exp_addr = 16'h0100;
    bit          halted = 0;
    int          acc_since = 0;
    bit          l_flush = 0, l_take = 0, l_acc = 0;
    logic [15:0] l_target = '0, l_req_addr = '0;

    function automatic logic [15:0] word_of(input logic [15:0] a);
        return (a * 16'd7) ^ 16'h5A3C;
    endfunction

    // error mark rule: address modulo 32 equals 22
    function automatic bit err_of(input logic [15:0] a);
        return a[4:0] == 5'd22;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    task automatic tick();
        bit tk, fl;
        @(negedge clk);
        // effects of the inputs applied at the edge just passed
        if (l_flush) begin
            exp_addr  = {l_target[15:1], 1'b0};
            halted    = 0;
            acc_since = 0;
            check(!dec_valid, "R8 queue empty after flush", dec_valid, 0);
            check(req_addr == {l_target[15:1], 1'b0}, "R8 fetch target", req_addr, {l_target[15:1], 1'b0});
            check(!fetch_fault, "R10/R8 no fault after flush", fetch_fault, 0);
        end else begin
            if (l_acc) begin
                acc_since++;
                check(req_addr == l_req_addr + 16'd2, "R2 address step", req_addr, l_req_addr + 16'd2);
            end
            if (l_take && err_of(exp_addr)) begin
                check(fetch_fault == 1'b1, "R6 fault pulse", fetch_fault, 1);
                check(fault_addr == exp_addr, "R6 fault address", fault_addr, exp_addr);
                halted = 1;
            end else begin
                check(!fetch_fault, "R5 no early fault", fetch_fault, 0);
                if (l_take) exp_addr = exp_addr + 16'd2;
            end
        end
        if (halted) begin
            check(!dec_valid && !req_valid, "R7 quiet while halted", {dec_valid, req_valid}, 0);
        end else if (dec_valid) begin
            check(dec_addr == exp_addr, "R4/R9 delivered address", dec_addr, exp_addr);
            check(dec_word == word_of(exp_addr), "R4 delivered word", dec_word, word_of(exp_addr));
        end

        // bus response decision first, then request acceptance
        if (wr_i != rd_i && $urandom_range(99) < p_rsp) begin
            rsp_valid = 1'b1;
            rsp_word  = word_of(pend[rd_i % 64]);
            rsp_err   = err_of(pend[rd_i % 64]);
            rd_i++;
        end else begin
            rsp_valid = 1'b0;
            rsp_word  = '0;
            rsp_err   = 1'b0;
        end
        req_ready  = ($urandom_range(99) < p_ready);
        l_acc      = req_valid && req_ready;
        l_req_addr = req_addr;
        if (l_acc) begin
            pend[wr_i % 64] = req_addr;
            wr_i++;
        end

        tk = dec_valid && !halted && (force_take || ($urandom_range(99) < p_take));
        fl = force_flush || ($urandom_range(99) < p_flush) || (halted && ($urandom_range(99) < p_hflush));
        l_target = force_flush ? force_target : 16'($urandom_range(16'hFFFF));
        dec_take   = tk;
        flush      = fl;
        flush_addr = l_target;
        l_take     = tk && !fl;
        l_flush    = fl;
        force_flush = 0;
        force_take  = 0;
    endtask

    task automatic redirect(input logic [15:0] t);
        force_flush  = 1;
        force_target = t;
        tick();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!dec_valid, "R1 empty after reset", dec_valid, 0);
        check(!fetch_fault, "R1 no fault after reset", fetch_fault, 0);
        check(req_addr == 16'h0100, "R1 reset address", req_addr, 16'h0100);

        // R3: idle decoder, eager bus
        p_ready = 100; p_rsp = 100; p_take = 0; p_flush = 0; p_hflush = 0;
        redirect(16'h0040);
        repeat (20) tick();
        check(acc_since == 4, "R3 requests after redirect", acc_since, 4);
        check(!req_valid, "R3 no request when full", req_valid, 0);
        check(dec_valid && dec_addr == 16'h0040, "R4 head is target", dec_addr, 16'h0040);

        // R5/R6/R7: marked word waits at head, then is taken
        redirect(16'h0036);
        repeat (10) tick();
        check(dec_valid && dec_addr == 16'h0036, "R5 marked word held", dec_addr, 16'h0036);
        force_take = 1;
        tick();
        tick();
        check(halted == 1, "R6 fault observed", halted, 1);
        repeat (5) tick();

        // R10: flush and take in the same cycle on a marked head
        redirect(16'h0036);
        repeat (10) tick();
        force_take   = 1;
        force_flush  = 1;
        force_target = 16'h0080;
        tick();
        tick();
        check(!halted, "R10 flush wins over take", halted, 0);

        // R8: odd target is aligned
        redirect(16'h1235);
        repeat (10) tick();
        check(dec_valid && dec_addr == 16'h1234, "R8 aligned target", dec_addr, 16'h1234);

        // R9: flush while requests are in flight, slow bus
        p_ready = 100; p_rsp = 20;
        redirect(16'h0200);
        tick();
        redirect(16'h0300);
        repeat (40) tick();
        check(dec_valid && dec_addr == 16'h0300, "R9 stale responses dropped", dec_addr, 16'h0300);

        // random mix
        p_ready = 70; p_rsp = 55; p_take = 60; p_flush = 3; p_hflush = 30;
        repeat (4000) tick();

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule